// File: doc/BRIEF.md
# Associative Key-Data Lookup Store

This block is a small content-addressable store. It holds up to 64 pairs, each made of a 22-bit key and a 32-bit data word. When a key is presented with the write strobe low, every stored key is compared with it at once, using exact equality only. One clock edge later the block returns a hit flag and the data word of the matching slot. If several slots hold the same key, the slot with the smallest index wins.

When the write strobe is high, the key and data are stored together in the slot named by an internal round-robin slot pointer. The caller never provides a write address. Once every slot has been used, the oldest slot is the next one overwritten. A write does not look for an existing copy of the key, so repeated keys take up separate slots.

A lookup or a write can be issued on every cycle. A synchronous, active-high reset empties the store.

Top module: `kd_lookup_store`

## Requirements
- R1: A synchronous reset, active high, drives `hit_o` and `data_o` to 0, marks every slot empty and returns the slot pointer to slot 0. No lookup hits until a new write has been made.
- R2: With `wr_en_i` high at a clock edge, `key_i` and `data_i` are stored together in the slot under the pointer. The pointer starts at slot 0 and advances by one on each write only.
- R3: With `wr_en_i` low at a clock edge, `hit_o` is 1 after that edge if any filled slot holds a key bit-for-bit equal to `key_i`, and `data_o` then carries that slot's data. A key differing in any single bit does not match.
- R4: A lookup that finds no match gives `hit_o` = 0 and `data_o` = 0 after the edge.
- R5: When several filled slots match, `data_o` carries the data of the lowest-numbered matching slot.
- R6: After slot 63 is written, the pointer wraps to slot 0, so the 65th write since reset replaces the oldest pair.
- R7: A write cycle leaves `hit_o` and `data_o` unchanged.
- R8: A write of a key that is already stored still takes the next slot, and the earlier copy stays in place.
- R9: Lookups issued on consecutive cycles each produce their own result one edge later, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_i | input | 22 | Key to search for, or to store |
| wr_en_i | input | 1 | 1 = store the pair, 0 = look up the key |
| data_i | input | 32 | Data word stored with the key on a write |
| hit_o | output | 1 | Registered result of the last lookup: 1 = match found |
| data_o | output | 32 | Registered data of the winning slot, or 0 on a miss |

## Verification
Each lookup result is due exactly one rising edge after the cycle in which the key is driven. A write's effects are due at the same edge: the stored pair is visible to a lookup issued in the following cycle, and the held output values are unchanged. The driver tags every item it pushes into the scoreboard with the cycle number in which that item is due. The monitor compares outputs on falling edges and pops only those items whose due cycle has been reached. This keeps every comparison exactly one register stage after its stimulus, including back-to-back lookups and writes placed between lookups.

// File: rtl/kls_pkg.sv
package kls_pkg;

  // Next slot in round-robin order over n slots.
  function automatic int next_slot(input int cur, input int n);
    if (cur >= n - 1) return 0;
    return cur + 1;
  endfunction

  // Output data policy: the winning slot's word on a hit, zero on a miss.
  function automatic logic [63:0] gate_word(input logic hit, input logic [63:0] word);
    return hit ? word : 64'd0;
  endfunction

endpackage

// File: rtl/kls_slot_ring.sv
module kls_slot_ring #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] slot_o
);
  import kls_pkg::*;

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_next_w;

  assign slot_next_w = IDX_W'(next_slot(int'(slot_q), ENTRIES));

  always_ff @(posedge clk) begin
    if (rst)          slot_q <= '0;
    else if (advance) slot_q <= slot_next_w;
  end

  assign slot_o = slot_q;

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(slot_q)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && slot_q == LAST_SLOT) |=> slot_q == '0); // R6
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (rst)
    advance |=> !$stable(slot_q)); // R2

endmodule

// File: rtl/kls_key_bank.sv
module kls_key_bank #(
  parameter int ENTRIES = 64,
  parameter int KEY_W   = 22,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [KEY_W-1:0]   probe_key,
  output logic [ENTRIES-1:0] match_o
);

  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [ENTRIES-1:0] filled_q;

  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (sel_w) key_q[s] <= wr_key;
    end

    always_ff @(posedge clk) begin
      if (rst)        filled_q[s] <= 1'b0;
      else if (sel_w) filled_q[s] <= 1'b1;
    end

    assign match_o[s] = filled_q[s] && (key_q[s] == probe_key);
  end

  AST_SLOT_FILLED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> filled_q[$past(wr_idx)]); // R2
  AST_FILL_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(filled_q)); // R8

endmodule

// File: rtl/kls_prio_pick.sv
module kls_prio_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic [ENTRIES-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (req[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/kls_data_bank.sv
module kls_data_bank #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx] <= wr_data;
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/kd_lookup_store.sv
module kd_lookup_store #(
  parameter int ENTRIES = 64,
  parameter int KEY_W   = 22,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  import kls_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0]   slot_w;
  logic [ENTRIES-1:0] match_w;
  logic [ENTRIES-1:0] grant_w;
  logic [IDX_W-1:0]   win_idx_w;
  logic               any_hit_w;
  logic [DATA_W-1:0]  win_data_w;
  logic [DATA_W-1:0]  gated_w;
  logic               lookup_w;

  logic              hit_q;
  logic [DATA_W-1:0] data_q;

  assign lookup_w = !wr_en_i;

  kls_slot_ring #(.ENTRIES(ENTRIES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .advance (wr_en_i),
    .slot_o  (slot_w)
  );

  kls_key_bank #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_keys (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .wr_idx    (slot_w),
    .wr_key    (key_i),
    .probe_key (key_i),
    .match_o   (match_w)
  );

  kls_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
    .req     (match_w),
    .grant_o (grant_w),
    .idx_o   (win_idx_w),
    .any_o   (any_hit_w)
  );

  kls_data_bank #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (wr_en_i),
    .wr_idx  (slot_w),
    .wr_data (data_i),
    .rd_idx  (win_idx_w),
    .rd_data (win_data_w)
  );

  assign gated_w = DATA_W'(gate_word(any_hit_w, 64'(win_data_w)));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      data_q <= '0;
    end else if (lookup_w) begin
      hit_q  <= any_hit_w;
      data_q <= gated_w;
    end
  end

  assign hit_o  = hit_q;
  assign data_o = data_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_w)); // R5
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (grant_w != '0) |-> (((grant_w - 1'b1) & match_w) == '0)); // R5
  AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (lookup_w && (match_w != '0)) |=> hit_o); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (data_o == '0)); // R4
  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> ($stable(hit_o) && $stable(data_o))); // R7

endmodule

// File: tb/kd_lookup_store_test.sv
module kd_lookup_store_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] key_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        hit_o;
  logic [31:0] data_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // Reference model of the store contents
  logic [21:0] m_key [64];
  logic [31:0] m_data [64];
  bit          m_val [64];
  int          m_ptr = 0;
  logic        last_hit = 1'b0;
  logic [31:0] last_data = '0;

  // Scoreboard queues
  int          q_due [$];
  logic        q_hit [$];
  logic [31:0] q_data [$];
  string       q_tag [$];

  kd_lookup_store uut (
    .clk(clk), .rst(rst), .key_i(key_i), .wr_en_i(wr_en_i),
    .data_i(data_i), .hit_o(hit_o), .data_o(data_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic note(input bit ok, input string tag, input logic h, input logic [31:0] d,
                      input logic eh, input logic [31:0] ed);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got hit=%0b data=%h, expected hit=%0b data=%h", tag, h, d, eh, ed);
    end
  endtask

  // Monitor: compares each item once its due cycle is reached.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      note((hit_o === q_hit[0]) && (data_o === q_data[0]), q_tag[0],
           hit_o, data_o, q_hit[0], q_data[0]);
      void'(q_due.pop_front());
      void'(q_hit.pop_front());
      void'(q_data.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic push(input logic h, input logic [31:0] d, input string tag);
    q_due.push_back(cyc + 1);
    q_hit.push_back(h);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) m_val[i] = 1'b0;
    m_ptr = 0;
    last_hit = 1'b0;
    last_data = '0;
  endtask

  task automatic do_lookup(input logic [21:0] k, input string tag);
    logic        h = 1'b0;
    logic [31:0] d = '0;
    @(negedge clk);
    rst = 1'b0; wr_en_i = 1'b0; key_i = k; data_i = 32'h0BAD_0BAD;
    for (int i = 0; i < 64; i++) begin
      if (!h && m_val[i] && m_key[i] == k) begin
        h = 1'b1;
        d = m_data[i];
      end
    end
    last_hit = h;
    last_data = d;
    push(h, d, tag);
  endtask

  task automatic do_write(input logic [21:0] k, input logic [31:0] d, input string tag);
    @(negedge clk);
    rst = 1'b0; wr_en_i = 1'b1; key_i = k; data_i = d;
    m_key[m_ptr] = k;
    m_data[m_ptr] = d;
    m_val[m_ptr] = 1'b1;
    m_ptr = (m_ptr == 63) ? 0 : m_ptr + 1;
    push(last_hit, last_data, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    model_clear();
    do_reset();
    // R1: outputs cleared by reset
    note((hit_o === 1'b0) && (data_o === 32'h0), "R1 reset outputs", hit_o, data_o, 1'b0, 32'h0);
    do_lookup(22'h000000, "R1 empty store key 0");
    do_lookup(22'h3FFFFF, "R1 empty store key all-ones");

    do_write(22'h000001, 32'hAAAA_0001, "R7 write after miss holds");
    do_write(22'h2ABCDE, 32'h1234_5678, "R7 write holds");
    do_write(22'h3FFFFF, 32'hDEAD_BEEF, "R7 write holds");
    do_lookup(22'h000001, "R3 hit slot 0");
    do_lookup(22'h2ABCDE, "R3 hit slot 1");
    do_lookup(22'h3FFFFF, "R3 hit slot 2");
    do_lookup(22'h200001, "R3 one-bit difference misses");
    do_lookup(22'h000005, "R4 absent key gives zeros");

    do_lookup(22'h2ABCDE, "R3 hit before write");
    do_write(22'h000777, 32'h0777_0777, "R7 write keeps hit data");
    do_write(22'h000001, 32'hA2A2_A2A2, "R8 duplicate key write");
    do_lookup(22'h000001, "R5 lowest slot wins on duplicate");
    do_lookup(22'h000777, "R2 stored at pointer");

    for (int i = 5; i < 64; i++)
      do_write(22'h010000 + 22'(i), 32'h5000_0000 + 32'(i), "R7 fill write holds");
    // R9: back-to-back lookups, one per cycle
    for (int i = 5; i < 64; i += 7)
      do_lookup(22'h010000 + 22'(i), "R9 back-to-back lookup");
    do_lookup(22'h01003F, "R2 last slot filled");

    do_write(22'h155555, 32'hCAFE_F00D, "R7 wrap write holds");
    do_lookup(22'h000001, "R6 slot 0 replaced, duplicate in slot 4 now wins");
    do_lookup(22'h155555, "R6 new pair in slot 0");
    do_write(22'h0F0F0F, 32'h0F0F_0F0F, "R7 write holds");
    do_lookup(22'h2ABCDE, "R6 slot 1 replaced so old key misses");
    do_lookup(22'h0F0F0F, "R6 new pair in slot 1");

    do_reset();
    note((hit_o === 1'b0) && (data_o === 32'h0), "R1 reset outputs mid-run", hit_o, data_o, 1'b0, 32'h0);
    do_lookup(22'h155555, "R1 store emptied by reset");
    do_write(22'h123456, 32'h6543_2100, "R7 write after reset holds");
    do_lookup(22'h123456, "R2 write after reset hits");
    do_lookup(22'h0F0F0F, "R1 old key still gone");

    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule